// File: doc/BRIEF.md
# Exception Acceptance and Vectoring Controller

This block sits beside the fetch stage of a processor core. It decides whether a pending event may be taken, in which order competing events are taken, and which address the core fetches from next. Six request classes come in: hard reset, general exception, TLB error, DMA error, external interrupt and user break. The block also reads the core's current PC and status word, the vector base and a flag that says the core is in low-power mode.

When it takes an event, the block saves the PC and status word into its shadow registers and records a 12-bit event code. It then asks the core to load a new status word with the block flag (bit `BL_BIT`) set, and issues a one-cycle fetch request to the target address. A return command reverses this in two steps. First the shadow status is loaded back into the core. Then control moves to the shadow PC. Software can overwrite both shadow registers before a return. The block flag decides the policy for each class. Interrupts and DMA errors wait while the flag is set. A user break that arrives while the flag is set is lost. An interrupt that arrives during low-power mode is taken even while the flag is set.

The state machine has four states:
- `ST_IDLE` goes to `ST_ENTER` when an event is taken. It goes to `ST_RET_SR` when a return is issued and no event is eligible.
- `ST_ENTER` goes back to `ST_IDLE`.
- `ST_RET_SR` goes to `ST_RET_JMP`.
- `ST_RET_JMP` goes back to `ST_IDLE`.

Requests are sampled only in `ST_IDLE`.

Top module: `exc_accept_ctrl`

## Requirements
- R1: A general exception fetches from vector base + 0x100 and writes `gen_code` to `exc_event`. A DMA error fetches from the same address and writes 0x5C0. A user break fetches from the same address and writes 0x1E0.
- R2: An interrupt fetches from vector base + 0x600 and writes its code to `int_event`. `exc_event` keeps its previous value.
- R3: A TLB error fetches from vector base + 0x400 and writes `tlb_code` to `exc_event`. A reset request fetches from `RESET_ADDR` (default 0xA000_0000) whatever the vector base is, and writes 0x000.
- R4: In the cycle after an event is taken, `fetch_valid` and `sr_load` are both high for one cycle. At that point `saved_pc` holds the PC from the cycle the event was taken, and `saved_sr` holds the status word from that cycle. `sr_next` equals that status word with bit 28 (the block flag) set.
- R5: An interrupt requested while the block flag is 1 is not taken and stays pending. It is taken in the first cycle that sees the flag at 0.
- R6: With `sleep_mode` high, an interrupt is taken even when the block flag is 1, and `lp_exit` is high in the fetch cycle.
- R7: A DMA error requested while the block flag is 1 stays pending and is taken once the flag is 0.
- R8: A user break requested while the block flag is 1 is discarded. No fetch follows after the flag clears.
- R9: A return command gives `sr_load` with `sr_next` equal to `saved_sr`, and then, in the next cycle, a fetch of `saved_pc`. No event is taken during this sequence, and an interrupt that arrives during it stays pending.
- R10: Writes through `spc_we`/`ssr_we` change `saved_pc`/`saved_sr`, and a later return uses the written values.
- R11: When several requests are eligible at once, the order is reset, general exception, TLB error, DMA error, interrupt, user break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low, synchronous |
| rst_req | input | 1 | Reset event request |
| gen_req | input | 1 | General exception request (pulse) |
| gen_code | input | 12 | Code for the general exception |
| tlb_req | input | 1 | TLB error request (pulse) |
| tlb_code | input | 12 | Code for the TLB error |
| dma_req | input | 1 | DMA error request (pulse) |
| irq_req | input | 1 | Interrupt request (pulse) |
| irq_code | input | 12 | Interrupt code |
| ubrk_req | input | 1 | User break request (pulse) |
| sleep_mode | input | 1 | Core is in low-power mode |
| vbr | input | 32 | Vector base |
| cur_pc | input | 32 | Current PC |
| cur_sr | input | 32 | Current status word |
| rte_cmd | input | 1 | Return-from-exception command |
| spc_we | input | 1 | Write enable for the saved PC |
| spc_wdata | input | 32 | Data for the saved PC |
| ssr_we | input | 1 | Write enable for the saved status |
| ssr_wdata | input | 32 | Data for the saved status |
| fetch_valid | output | 1 | Redirect the fetch this cycle |
| fetch_addr | output | 32 | Redirect target |
| sr_load | output | 1 | Core loads `sr_next` |
| sr_next | output | 32 | New status word |
| saved_pc | output | 32 | Shadow PC |
| saved_sr | output | 32 | Shadow status word |
| exc_event | output | 12 | Event code for resets and exceptions |
| int_event | output | 12 | Event code for interrupts |
| lp_exit | output | 1 | Wake from low-power mode |

## Verification
A wrong selection register or a wrong vector shows up as a bad `fetch_addr` or event code in the very next cycle after the event is taken. The bench checks both in that cycle. A lost or stuck pending bit shows only later: as a missing fetch after the block flag clears, or as a fetch while the flag is still set. For that reason the bench watches several cycles on each side of the flag change. A wrong state order in the return path shows up as `sr_load` and `fetch_valid` out of step over two cycles.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ENTER, ST_RET_SR, ST_RET_JMP} exc_state_e;
    localparam int NUM_SRC = 6;
    // index order is the priority order, lowest index wins
    typedef enum logic [2:0] {
        SRC_RESET = 3'd0, SRC_GEN = 3'd1, SRC_TLB = 3'd2,
        SRC_DMA = 3'd3, SRC_IRQ = 3'd4, SRC_UBRK = 3'd5
    } exc_src_e;
    localparam logic [31:0] OFS_GENERAL = 32'h0000_0100;
    localparam logic [31:0] OFS_TLB     = 32'h0000_0400;
    localparam logic [31:0] OFS_IRQ     = 32'h0000_0600;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N = 6
) (
    input  logic [N-1:0] elig,
    output logic [N-1:0] grant,
    output logic         any
);
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        any = |elig;
    end

    always_comb begin
        if (any) begin
            AST_GRANT_ONEHOT: assert ($onehot(grant) && ((grant & elig) == grant)); // R11
        end
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] RESET_ADDR = 32'hA000_0000
) (
    input  exc_src_e      src,
    input  logic [AW-1:0] vbr,
    output logic [AW-1:0] addr
);
    always_comb begin
        unique case (src)
            SRC_RESET: addr = AW'(RESET_ADDR);
            SRC_TLB:   addr = vbr + AW'(OFS_TLB);
            SRC_IRQ:   addr = vbr + AW'(OFS_IRQ);
            default:   addr = vbr + AW'(OFS_GENERAL);
        endcase
    end
endmodule

// File: rtl/exc_accept_ctrl.sv
module exc_accept_ctrl
    import exc_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          DW         = 32,
    parameter int          CW         = 12,
    parameter int          BL_BIT     = 28,
    parameter logic [31:0] RESET_ADDR = 32'hA000_0000,
    parameter logic [11:0] RESET_CODE = 12'h000,
    parameter logic [11:0] DMA_CODE   = 12'h5C0,
    parameter logic [11:0] UBRK_CODE  = 12'h1E0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_req,
    input  logic          gen_req,
    input  logic [CW-1:0] gen_code,
    input  logic          tlb_req,
    input  logic [CW-1:0] tlb_code,
    input  logic          dma_req,
    input  logic          irq_req,
    input  logic [CW-1:0] irq_code,
    input  logic          ubrk_req,
    input  logic          sleep_mode,
    input  logic [AW-1:0] vbr,
    input  logic [AW-1:0] cur_pc,
    input  logic [DW-1:0] cur_sr,
    input  logic          rte_cmd,
    input  logic          spc_we,
    input  logic [AW-1:0] spc_wdata,
    input  logic          ssr_we,
    input  logic [DW-1:0] ssr_wdata,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic          sr_load,
    output logic [DW-1:0] sr_next,
    output logic [AW-1:0] saved_pc,
    output logic [DW-1:0] saved_sr,
    output logic [CW-1:0] exc_event,
    output logic [CW-1:0] int_event,
    output logic          lp_exit
);
    localparam logic [DW-1:0] BL_MASK = DW'(1) << BL_BIT;

    exc_state_e    state_q;
    exc_src_e      sel_src, cls_q;
    logic [AW-1:0] vec_addr, vec_q, spc_q;
    logic [DW-1:0] ssr_q;
    logic [CW-1:0] expevt_q, intevt_q, irq_code_q, irq_code_live, evt_code;
    logic          irq_pend_q, dma_pend_q, wake_q;
    logic          irq_live, dma_live, bl, in_idle, take;
    logic [NUM_SRC-1:0] elig, grant;
    logic          any;

    assign bl            = cur_sr[BL_BIT];
    assign in_idle       = (state_q == ST_IDLE);
    assign irq_live      = irq_pend_q | irq_req;
    assign dma_live      = dma_pend_q | dma_req;
    assign irq_code_live = irq_req ? irq_code : irq_code_q;

    always_comb begin
        elig           = '0;
        elig[SRC_RESET] = rst_req;
        elig[SRC_GEN]   = gen_req;
        elig[SRC_TLB]   = tlb_req;
        elig[SRC_DMA]   = dma_live & ~bl;
        elig[SRC_IRQ]   = irq_live & (~bl | sleep_mode);
        elig[SRC_UBRK]  = ubrk_req & ~bl;
    end

    exc_arbiter #(.N(NUM_SRC)) u_arb (.elig(elig), .grant(grant), .any(any));

    assign take = in_idle & any;

    always_comb begin
        sel_src = SRC_RESET;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (grant[i]) sel_src = exc_src_e'(3'(i));
        end
    end

    exc_vector #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_vec (
        .src(sel_src), .vbr(vbr), .addr(vec_addr)
    );

    always_comb begin
        unique case (sel_src)
            SRC_RESET: evt_code = RESET_CODE;
            SRC_GEN:   evt_code = gen_code;
            SRC_TLB:   evt_code = tlb_code;
            SRC_DMA:   evt_code = DMA_CODE;
            SRC_UBRK:  evt_code = UBRK_CODE;
            default:   evt_code = expevt_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (take) state_q <= ST_ENTER;
                            else if (rte_cmd) state_q <= ST_RET_SR;
                ST_ENTER:   state_q <= ST_IDLE;
                ST_RET_SR:  state_q <= ST_RET_JMP;
                ST_RET_JMP: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // captured context, pending requests, event registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q      <= SRC_RESET;
            vec_q      <= '0;
            spc_q      <= '0;
            ssr_q      <= '0;
            expevt_q   <= '0;
            intevt_q   <= '0;
            irq_pend_q <= 1'b0;
            irq_code_q <= '0;
            dma_pend_q <= 1'b0;
            wake_q     <= 1'b0;
        end else begin
            irq_code_q <= irq_code_live;
            irq_pend_q <= irq_live & ~(take && sel_src == SRC_IRQ);
            dma_pend_q <= dma_live & ~(take && sel_src == SRC_DMA);
            if (take) begin
                cls_q  <= sel_src;
                vec_q  <= vec_addr;
                spc_q  <= cur_pc;
                ssr_q  <= cur_sr;
                wake_q <= (sel_src == SRC_IRQ) && sleep_mode;
                if (sel_src == SRC_IRQ) intevt_q <= irq_code_live;
                else                    expevt_q <= evt_code;
            end else begin
                wake_q <= 1'b0;
                if (spc_we) spc_q <= spc_wdata;
                if (ssr_we) ssr_q <= ssr_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        fetch_valid = 1'b0;
        fetch_addr  = '0;
        sr_load     = 1'b0;
        sr_next     = '0;
        lp_exit     = 1'b0;
        unique case (state_q)
            ST_ENTER: begin
                fetch_valid = 1'b1;
                fetch_addr  = vec_q;
                sr_load     = 1'b1;
                sr_next     = ssr_q | BL_MASK;
                lp_exit     = wake_q;
            end
            ST_RET_SR: begin
                sr_load = 1'b1;
                sr_next = ssr_q;
            end
            ST_RET_JMP: begin
                fetch_valid = 1'b1;
                fetch_addr  = spc_q;
            end
            default: ;
        endcase
    end

    assign saved_pc  = spc_q;
    assign saved_sr  = ssr_q;
    assign exc_event = expevt_q;
    assign int_event = intevt_q;

    AST_ENTRY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTER) |-> (sr_load && fetch_valid && sr_next[BL_BIT])); // R4
    AST_IRQ_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && irq_pend_q && bl && !sleep_mode) |=> irq_pend_q); // R5
    AST_WAKE_ONLY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        lp_exit |-> (cls_q == SRC_IRQ)); // R6
    AST_UBRK_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_idle && ubrk_req && bl) |=> !(state_q == ST_ENTER && cls_q == SRC_UBRK)); // R8
    AST_RET_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET_JMP) |-> (fetch_valid && fetch_addr == spc_q && $past(sr_load))); // R9
    AST_NO_TAKE_IN_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET_SR || state_q == ST_RET_JMP) |=> (state_q != ST_ENTER)); // R9
endmodule

// File: tb/exc_accept_ctrl_test.sv
module exc_accept_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req = 0, gen_req = 0, tlb_req = 0, dma_req = 0, irq_req = 0, ubrk_req = 0;
    logic [11:0] gen_code = 0, tlb_code = 0, irq_code = 0;
    logic        sleep_mode = 0, rte_cmd = 0, spc_we = 0, ssr_we = 0;
    logic [31:0] vbr = 32'h8000_0000, cur_pc = 0, cur_sr = 0, spc_wdata = 0, ssr_wdata = 0;
    logic        fetch_valid, sr_load, lp_exit;
    logic [31:0] fetch_addr, sr_next, saved_pc, saved_sr;
    logic [11:0] exc_event, int_event;
    int vectors = 0, miscompares = 0;
    localparam logic [31:0] FLAG = 32'h1000_0000;

    always #5 clk = ~clk;

    exc_accept_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .gen_req(gen_req), .gen_code(gen_code),
        .tlb_req(tlb_req), .tlb_code(tlb_code), .dma_req(dma_req), .irq_req(irq_req),
        .irq_code(irq_code), .ubrk_req(ubrk_req), .sleep_mode(sleep_mode), .vbr(vbr),
        .cur_pc(cur_pc), .cur_sr(cur_sr), .rte_cmd(rte_cmd), .spc_we(spc_we),
        .spc_wdata(spc_wdata), .ssr_we(ssr_we), .ssr_wdata(ssr_wdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .sr_load(sr_load),
        .sr_next(sr_next), .saved_pc(saved_pc), .saved_sr(saved_sr),
        .exc_event(exc_event), .int_event(int_event), .lp_exit(lp_exit)
    );

    // core model: takes the offered status word
    always @(negedge clk) if (rst_n && sr_load) cur_sr <= sr_next;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_no_fetch(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            chk(req, {31'd0, fetch_valid}, 32'd0);
        end
    endtask

    task automatic t_reset();
        chk("R4 reset fetch_valid", {31'd0, fetch_valid}, 0);
        chk("R4 reset saved_pc", saved_pc, 0);
        chk("R1 reset exc_event", {20'd0, exc_event}, 0);
    endtask

    task automatic t_general();
        cur_pc = 32'h0000_1000; cur_sr = 32'h0000_00F0; vbr = 32'h8000_0000;
        gen_req = 1; gen_code = 12'h180;
        tick(); gen_req = 0;
        chk("R1 gen fetch_valid", {31'd0, fetch_valid}, 1);
        chk("R1 gen addr", fetch_addr, 32'h8000_0100);
        chk("R1 gen code", {20'd0, exc_event}, 32'h180);
        chk("R4 saved_pc", saved_pc, 32'h1000);
        chk("R4 saved_sr", saved_sr, 32'hF0);
        chk("R4 sr_next flag", sr_next, 32'h1000_00F0);
        chk("R4 sr_load", {31'd0, sr_load}, 1);
        tick(); cur_sr = 0;
    endtask

    task automatic t_tlb();
        vbr = 32'h8C00_0000; tlb_req = 1; tlb_code = 12'h040;
        tick(); tlb_req = 0;
        chk("R3 tlb addr", fetch_addr, 32'h8C00_0400);
        chk("R3 tlb code", {20'd0, exc_event}, 32'h040);
        tick(); cur_sr = 0;
    endtask

    task automatic t_irq();
        irq_req = 1; irq_code = 12'h320;
        tick(); irq_req = 0;
        chk("R2 irq addr", fetch_addr, 32'h8C00_0600);
        chk("R2 int_event", {20'd0, int_event}, 32'h320);
        chk("R2 exc_event kept", {20'd0, exc_event}, 32'h040);
        tick(); cur_sr = 0;
    endtask

    task automatic t_reset_req();
        vbr = 32'h1234_0000; rst_req = 1;
        tick(); rst_req = 0;
        chk("R3 reset addr", fetch_addr, 32'hA000_0000);
        chk("R3 reset code", {20'd0, exc_event}, 32'h000);
        tick(); cur_sr = 0; vbr = 32'h8000_0000;
    endtask

    task automatic t_irq_hold();
        cur_sr = FLAG; irq_req = 1; irq_code = 12'h2A0;
        tick(); irq_req = 0;
        chk("R5 held while flag", {31'd0, fetch_valid}, 0);
        idle_no_fetch("R5 held while flag", 3);
        cur_sr = 0;
        tick();
        chk("R5 taken after clear", fetch_addr, 32'h8000_0600);
        chk("R5 code", {20'd0, int_event}, 32'h2A0);
        chk("R5 fetch_valid", {31'd0, fetch_valid}, 1);
        tick(); cur_sr = 0;
    endtask

    task automatic t_wake();
        cur_sr = FLAG; sleep_mode = 1; irq_req = 1; irq_code = 12'h3C0;
        tick(); irq_req = 0;
        chk("R6 wake fetch", {31'd0, fetch_valid}, 1);
        chk("R6 lp_exit", {31'd0, lp_exit}, 1);
        chk("R6 int_event", {20'd0, int_event}, 32'h3C0);
        sleep_mode = 0;
        tick(); cur_sr = 0;
        chk("R6 lp_exit one cycle", {31'd0, lp_exit}, 0);
    endtask

    task automatic t_dma();
        cur_sr = FLAG; dma_req = 1;
        tick(); dma_req = 0;
        idle_no_fetch("R7 dma held", 2);
        cur_sr = 0;
        tick();
        chk("R7 dma addr", fetch_addr, 32'h8000_0100);
        chk("R7 dma code", {20'd0, exc_event}, 32'h5C0);
        tick(); cur_sr = 0;
    endtask

    task automatic t_ubrk();
        cur_sr = FLAG; ubrk_req = 1;
        tick(); ubrk_req = 0;
        tick(); cur_sr = 0;
        idle_no_fetch("R8 break discarded", 3);
        ubrk_req = 1;
        tick(); ubrk_req = 0;
        chk("R8 break taken flag clear", {20'd0, exc_event}, 32'h1E0);
        chk("R1 break addr", fetch_addr, 32'h8000_0100);
        tick(); cur_sr = 0;
    endtask

    task automatic t_rte();
        cur_sr = FLAG; spc_we = 1; spc_wdata = 32'h2222_0000; ssr_we = 1; ssr_wdata = 32'h55;
        tick(); spc_we = 0; ssr_we = 0;
        chk("R10 spc written", saved_pc, 32'h2222_0000);
        chk("R10 ssr written", saved_sr, 32'h55);
        rte_cmd = 1;
        tick(); rte_cmd = 0;
        chk("R9 sr_load", {31'd0, sr_load}, 1);
        chk("R10 restored sr", sr_next, 32'h55);
        chk("R9 no fetch yet", {31'd0, fetch_valid}, 0);
        sleep_mode = 1; irq_req = 1; irq_code = 12'h400;
        tick(); irq_req = 0; sleep_mode = 0;
        chk("R9 jump", fetch_addr, 32'h2222_0000);
        chk("R9 jump valid", {31'd0, fetch_valid}, 1);
        tick();
        chk("R9 nothing taken in sequence", {31'd0, fetch_valid}, 0);
        tick();
        chk("R9 pending irq after", fetch_addr, 32'h8000_0600);
        chk("R9 pending irq code", {20'd0, int_event}, 32'h400);
        tick(); cur_sr = 0;
    endtask

    task automatic t_priority();
        gen_req = 1; gen_code = 12'h1A0; dma_req = 1; irq_req = 1; irq_code = 12'h500; ubrk_req = 1;
        tick(); gen_req = 0; dma_req = 0; irq_req = 0; ubrk_req = 0;
        chk("R11 general first", {20'd0, exc_event}, 32'h1A0);
        tick(); cur_sr = 0;
        tick();
        chk("R11 dma second", {20'd0, exc_event}, 32'h5C0);
        tick(); cur_sr = 0;
        tick();
        chk("R11 irq third", {20'd0, int_event}, 32'h500);
        chk("R11 irq addr", fetch_addr, 32'h8000_0600);
        tick(); cur_sr = 0;
        idle_no_fetch("R11 break not latched", 3);
    endtask

    initial begin
        #200_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_general();
        t_tlb();
        t_irq();
        t_reset_req();
        t_irq_hold();
        t_wake();
        t_dma();
        t_ubrk();
        t_rte();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule